// File: doc/BRIEF.md
# Frame Check Sequence Append and Strip Unit

This unit sits between a byte-wide frame buffer port and the serial byte stream of a token-bus medium access controller. It handles the 32-bit frame check sequence (FCS) in both directions. The CRC is the common IEEE 802 CRC-32, updated one byte per clock. The engine runs least-significant bit first, starts from all ones, and the transmitted FCS is the complement of the register.

On the transmit side, frames arrive with start and end markers and a class tag (data or control) and are passed through. A four-byte FCS follows the last byte, lowest-order byte first. When the transmit CRC-off mode bit is set, data frames go out exactly as supplied, because the buffer already holds their trailing check bytes. Control frames get an FCS whatever that bit says.

On the receive side, the CRC is checked on every frame by comparing the register, after the last byte, with the good-frame residue 0xDEBB20E3. A four-byte tail delay line lets the unit strip the FCS without knowing the frame length in advance. When the copy mode bit is set, the FCS is delivered as payload instead. At the end of each frame a one-cycle status reports the CRC-error flag, the accept flag and the number of bytes delivered.

The transmit path has three states. `TX_IDLE` moves to `TX_BODY` when it accepts a start byte that is not also an end byte. `TX_IDLE` or `TX_BODY` moves to `TX_APPEND` when it accepts an end byte that needs an FCS, and back to `TX_IDLE` when the end byte needs none. `TX_APPEND` returns to `TX_IDLE` after the fourth FCS byte. The receive path has two states. `RX_IDLE` moves to `RX_FRAME` on a start byte that is not an end byte, and `RX_FRAME` moves back to `RX_IDLE` on the end byte.

Top module: `fcs_frame_unit`

## Requirements
- R1: After reset, `tx_in_ready` is 1, and `tx_out_valid`, `rx_mem_valid` and `rx_stat_valid` are 0.
- R2: A data frame sent while `tx_crc_off` is 0 leaves as the payload followed by four FCS bytes, bits 7:0 of the complemented CRC first. `tx_out_eof` is set only on the last FCS byte (payload "123456789" ends in 0x26 0x39 0xF4 0xCB).
- R3: A data frame sent while `tx_crc_off` is 1 leaves unchanged, with no bytes added and `tx_out_eof` on its last payload byte.
- R4: A control frame (`tx_in_ctrl`=1 at the start byte) always gets the four FCS bytes, whatever the value of `tx_crc_off`.
- R5: While the FCS is appended, `tx_in_ready` is 0 for exactly four cycles. Output bytes flow on consecutive cycles, so a frame of n bytes fed without gaps spans n+4 cycles at the output.
- R6: With `rx_crc_keep` at 0, the last four received bytes are withheld, and the status count is the frame length minus four. No byte is delivered before the fifth byte of the frame has been received.
- R7: With `rx_crc_keep` at 1, every received byte is delivered, and the status count is the full frame length.
- R8: The CRC is checked in both keep modes: `rx_stat_crc_err` is 1 exactly when the residue differs from 0xDEBB20E3.
- R9: `rx_stat_accept` is 1 for a frame with a good CRC. For a frame with a bad CRC it equals `rx_mask_crc_err` as sampled with the end byte.
- R10: Delivered bytes and the status each appear one cycle after the input byte that produces them. `rx_mem_last` marks the final delivered byte of a frame, and the status follows the end byte by one cycle.
- R11: The transmit class tag and the receive keep mode are taken from the start byte only. Changing either later in the same frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_crc_off | input | 1 | 1: no FCS generated for data frames |
| rx_crc_keep | input | 1 | 1: deliver received FCS as payload |
| rx_mask_crc_err | input | 1 | 1: accept frames with a CRC error |
| tx_in_valid | input | 1 | Transmit byte present |
| tx_in_data | input | 8 | Transmit byte |
| tx_in_sof | input | 1 | First byte of a transmit frame |
| tx_in_eof | input | 1 | Last byte of a transmit frame |
| tx_in_ctrl | input | 1 | Frame class at start byte: 1 control, 0 data |
| tx_in_ready | output | 1 | Transmit byte accepted this cycle when valid |
| tx_out_valid | output | 1 | Byte to the MAC stream |
| tx_out_data | output | 8 | Byte to the MAC stream |
| tx_out_sof | output | 1 | First output byte of a frame |
| tx_out_eof | output | 1 | Last output byte of a frame |
| rx_in_valid | input | 1 | Received byte present |
| rx_in_data | input | 8 | Received byte |
| rx_in_sof | input | 1 | First received byte of a frame |
| rx_in_eof | input | 1 | Last received byte of a frame |
| rx_mem_valid | output | 1 | Byte delivered to memory |
| rx_mem_data | output | 8 | Delivered byte |
| rx_mem_last | output | 1 | Final delivered byte of the frame |
| rx_stat_valid | output | 1 | End-of-frame status strobe |
| rx_stat_crc_err | output | 1 | CRC residue mismatch |
| rx_stat_accept | output | 1 | Frame accepted |
| rx_stat_count | output | CNT_W | Number of bytes delivered for the frame |

## Verification
On the receive side, the status of one frame and the first byte of the next can fall in the same cycle. The end byte's status goes out while the next start byte clears the count, fill level and CRC that produced it. The bench provokes this with two frames driven back to back, the second starting the cycle after the first ends, with the keep mode flipped at the second start. It judges the result by two status strobes seven cycles apart, carrying counts 2 and 7. A single-byte transmit payload, where start and end mark the same byte, is also covered. There the class sampling and the FCS append decision occur in the same cycle.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int          BYTE_W           = 8;
    localparam int          FCS_BYTES        = 4;
    localparam int          CRC_W            = BYTE_W * FCS_BYTES;
    localparam logic [CRC_W-1:0] CRC_SEED         = '1;
    localparam logic [CRC_W-1:0] CRC_POLY_LSBF    = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_GOOD_RESIDUE = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_BODY   = 2'd1,
        TX_APPEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_e;

    // One byte into an LSB-first CRC-32 register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_LSBF;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_tx_path.sv
module fcs_tx_path
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_crc_off,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_ctrl,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof
);
    localparam int              IDX_W    = $clog2(FCS_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

    tx_state_e         state_q, state_d;
    logic [CRC_W-1:0]  crc_q;
    logic              cls_ctrl_q;
    logic [IDX_W-1:0]  idx_q;

    logic              accept, start, take, is_ctrl, add_fcs;
    logic [CRC_W-1:0]  crc_base, crc_nxt, fcs_word;
    logic [BYTE_W-1:0] fcs_byte;

    assign in_ready = (state_q != TX_APPEND);
    assign accept   = in_valid && in_ready;
    assign start    = accept && in_sof;
    assign take     = start || (accept && (state_q == TX_BODY));
    assign is_ctrl  = start ? in_ctrl : cls_ctrl_q;
    assign add_fcs  = is_ctrl || !mode_crc_off;
    assign crc_base = start ? CRC_SEED : crc_q;
    assign crc_nxt  = crc_step(crc_base, in_data);
    assign fcs_word = ~crc_q;
    assign fcs_byte = fcs_word[BYTE_W*idx_q +: BYTE_W];

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE, TX_BODY: begin
                if (take && in_eof) state_d = add_fcs ? TX_APPEND : TX_IDLE;
                else if (take)      state_d = TX_BODY;
            end
            TX_APPEND: begin
                if (idx_q == IDX_LAST) state_d = TX_IDLE;
            end
        endcase
    end

    // State register and frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            crc_q      <= CRC_SEED;
            cls_ctrl_q <= 1'b0;
            idx_q      <= '0;
        end else begin
            state_q <= state_d;
            if (take)  crc_q      <= crc_nxt;
            if (start) cls_ctrl_q <= in_ctrl;
            if (state_q == TX_APPEND) idx_q <= idx_q + 1'b1;
            else                      idx_q <= '0;
        end
    end

    // Registered output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            unique case (state_q)
                TX_APPEND: begin
                    out_valid <= 1'b1;
                    out_data  <= fcs_byte;
                    out_sof   <= 1'b0;
                    out_eof   <= (idx_q == IDX_LAST);
                end
                TX_IDLE, TX_BODY: begin
                    out_valid <= take;
                    out_data  <= in_data;
                    out_sof   <= start;
                    out_eof   <= take && in_eof && !add_fcs;
                end
            endcase
        end
    end

    // Control frame end always followed by an FCS phase
    assert_ctrl_gets_fcs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eof && is_ctrl) |=> !in_ready);

    // Data frame with CRC off closes on its own last byte
    assert_data_no_fcs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eof && !is_ctrl && mode_crc_off) |=> (out_eof && in_ready));

    // Every stalled cycle produces an output byte on the next
    assert_append_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid);

    // Stall lasts longer than one cycle
    assert_ready_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |=> !in_ready);

endmodule

// File: rtl/fcs_rx_path.sv
module fcs_rx_path
    import fcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_keep_fcs,
    input  logic              mask_crc_err,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              mem_valid,
    output logic [BYTE_W-1:0] mem_data,
    output logic              mem_last,
    output logic              stat_valid,
    output logic              stat_crc_err,
    output logic              stat_accept,
    output logic [CNT_W-1:0]  stat_count
);
    localparam int              FILL_W    = $clog2(FCS_BYTES + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(FCS_BYTES);

    rx_state_e                          state_q, state_d;
    logic                               keep_q;
    logic [FILL_W-1:0]                  fill_q;
    logic [CNT_W-1:0]                   cnt_q;
    logic [CRC_W-1:0]                   crc_q;
    logic [FCS_BYTES-1:0][BYTE_W-1:0]   tail_q;

    logic              start, take, keep_now, full, emit, crc_bad;
    logic [FILL_W-1:0] fill_base;
    logic [CNT_W-1:0]  cnt_base, cnt_nxt;
    logic [CRC_W-1:0]  crc_nxt;
    logic [BYTE_W-1:0] emit_data;

    assign start     = in_valid && in_sof;
    assign take      = start || (in_valid && (state_q == RX_FRAME));
    assign keep_now  = start ? mode_keep_fcs : keep_q;
    assign fill_base = start ? '0 : fill_q;
    assign full      = (fill_base == FILL_FULL);
    assign emit      = take && (keep_now || full);
    assign emit_data = keep_now ? in_data : tail_q[FCS_BYTES-1];
    assign cnt_base  = start ? '0 : cnt_q;
    assign cnt_nxt   = cnt_base + CNT_W'(emit);
    assign crc_nxt   = crc_step(start ? CRC_SEED : crc_q, in_data);
    assign crc_bad   = (crc_nxt != CRC_GOOD_RESIDUE);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (take && !in_eof) state_d = RX_FRAME;
            RX_FRAME: if (take && in_eof)  state_d = RX_IDLE;
        endcase
    end

    // State register, tail delay line and running frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            keep_q  <= 1'b0;
            fill_q  <= '0;
            cnt_q   <= '0;
            crc_q   <= CRC_SEED;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                keep_q <= keep_now;
                fill_q <= full ? fill_base : fill_base + 1'b1;
                cnt_q  <= cnt_nxt;
                crc_q  <= crc_nxt;
                tail_q <= {tail_q[FCS_BYTES-2:0], in_data};
            end
        end
    end

    // Registered delivery and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid    <= 1'b0;
            mem_data     <= '0;
            mem_last     <= 1'b0;
            stat_valid   <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_accept  <= 1'b0;
            stat_count   <= '0;
        end else begin
            mem_valid  <= emit;
            mem_data   <= emit_data;
            mem_last   <= emit && in_eof;
            stat_valid <= take && in_eof;
            if (take && in_eof) begin
                stat_crc_err <= crc_bad;
                stat_accept  <= !crc_bad || mask_crc_err;
                stat_count   <= cnt_nxt;
            end
        end
    end

    // Bad CRC without mask is rejected
    assert_reject_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_crc_err && !$past(mask_crc_err)) |-> !stat_accept);

    // Good CRC is always accepted
    assert_accept_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_crc_err) |-> stat_accept);

    // Last marker only on a delivered byte
    assert_last_is_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_last |-> mem_valid);

    // Strip mode never delivers the first byte straight away
    assert_strip_holds_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode_keep_fcs) |=> !mem_valid);

endmodule

// File: rtl/fcs_frame_unit.sv
module fcs_frame_unit
    import fcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_crc_off,
    input  logic              rx_crc_keep,
    input  logic              rx_mask_crc_err,
    input  logic              tx_in_valid,
    input  logic [BYTE_W-1:0] tx_in_data,
    input  logic              tx_in_sof,
    input  logic              tx_in_eof,
    input  logic              tx_in_ctrl,
    output logic              tx_in_ready,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_sof,
    output logic              tx_out_eof,
    input  logic              rx_in_valid,
    input  logic [BYTE_W-1:0] rx_in_data,
    input  logic              rx_in_sof,
    input  logic              rx_in_eof,
    output logic              rx_mem_valid,
    output logic [BYTE_W-1:0] rx_mem_data,
    output logic              rx_mem_last,
    output logic              rx_stat_valid,
    output logic              rx_stat_crc_err,
    output logic              rx_stat_accept,
    output logic [CNT_W-1:0]  rx_stat_count
);

    fcs_tx_path u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_crc_off (tx_crc_off),
        .in_valid     (tx_in_valid),
        .in_data      (tx_in_data),
        .in_sof       (tx_in_sof),
        .in_eof       (tx_in_eof),
        .in_ctrl      (tx_in_ctrl),
        .in_ready     (tx_in_ready),
        .out_valid    (tx_out_valid),
        .out_data     (tx_out_data),
        .out_sof      (tx_out_sof),
        .out_eof      (tx_out_eof)
    );

    fcs_rx_path #(.CNT_W(CNT_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_keep_fcs (rx_crc_keep),
        .mask_crc_err  (rx_mask_crc_err),
        .in_valid      (rx_in_valid),
        .in_data       (rx_in_data),
        .in_sof        (rx_in_sof),
        .in_eof        (rx_in_eof),
        .mem_valid     (rx_mem_valid),
        .mem_data      (rx_mem_data),
        .mem_last      (rx_mem_last),
        .stat_valid    (rx_stat_valid),
        .stat_crc_err  (rx_stat_crc_err),
        .stat_accept   (rx_stat_accept),
        .stat_count    (rx_stat_count)
    );

endmodule

// File: tb/test_fcs_frame_unit.sv
`timescale 1ns/1ps
module test_fcs_frame_unit;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_crc_off = 1'b0, rx_crc_keep = 1'b0, rx_mask_crc_err = 1'b0;
    logic tx_in_valid = 1'b0, tx_in_sof = 1'b0, tx_in_eof = 1'b0, tx_in_ctrl = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic tx_in_ready, tx_out_valid, tx_out_sof, tx_out_eof;
    logic [7:0] tx_out_data;
    logic rx_in_valid = 1'b0, rx_in_sof = 1'b0, rx_in_eof = 1'b0;
    logic [7:0] rx_in_data = '0;
    logic rx_mem_valid, rx_mem_last, rx_stat_valid, rx_stat_crc_err, rx_stat_accept;
    logic [7:0] rx_mem_data;
    logic [CNT_W-1:0] rx_stat_count;

    fcs_frame_unit #(.CNT_W(CNT_W)) i_fcs_frame_unit (
        .clk(clk), .rst_n(rst_n),
        .tx_crc_off(tx_crc_off), .rx_crc_keep(rx_crc_keep), .rx_mask_crc_err(rx_mask_crc_err),
        .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_sof(tx_in_sof),
        .tx_in_eof(tx_in_eof), .tx_in_ctrl(tx_in_ctrl), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_sof(tx_out_sof), .tx_out_eof(tx_out_eof),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_in_sof(rx_in_sof), .rx_in_eof(rx_in_eof),
        .rx_mem_valid(rx_mem_valid), .rx_mem_data(rx_mem_data), .rx_mem_last(rx_mem_last),
        .rx_stat_valid(rx_stat_valid), .rx_stat_crc_err(rx_stat_crc_err),
        .rx_stat_accept(rx_stat_accept), .rx_stat_count(rx_stat_count)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Vector: [15] ctrl, [14] tx_crc_off, [13] rx_crc_keep, [12] mask, [11] corrupt, [7:0] length
    localparam logic [15:0] VEC [8] = '{16'h0006, 16'h6005, 16'hC807, 16'hB803,
                                        16'h1001, 16'h5809, 16'h800C, 16'h7002};

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [7:0] pay [64];
    logic [7:0] rxf [64];
    bit         rs  [64];
    bit         re  [64];

    logic [7:0] txcap [64]; bit txs [64]; bit txe [64]; int txcyc [64]; int txn = 0;
    logic [7:0] rmcap [64]; bit rml [64]; int rmcyc [64]; int rmn = 0;
    int st_cnt [4]; bit st_err [4]; bit st_acc [4]; int st_cyc [4]; int stn = 0;
    int rdy_low = 0;
    int sof_cyc = 0, eof_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tx_out_valid && txn < 64) begin
            txcap[txn] = tx_out_data; txs[txn] = tx_out_sof; txe[txn] = tx_out_eof;
            txcyc[txn] = cyc; txn++;
        end
        if (rx_mem_valid && rmn < 64) begin
            rmcap[rmn] = rx_mem_data; rml[rmn] = rx_mem_last; rmcyc[rmn] = cyc; rmn++;
        end
        if (rx_stat_valid && stn < 4) begin
            st_cnt[stn] = int'(rx_stat_count); st_err[stn] = rx_stat_crc_err;
            st_acc[stn] = rx_stat_accept; st_cyc[stn] = cyc; stn++;
        end
        if (rst_n && !tx_in_ready) rdy_low++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference FCS, written MSB-first with bit-reflected bytes
    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c, r;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ pay[i][b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        for (int k = 0; k < 32; k++) r[k] = c[31-k];
        return ~r;
    endfunction

    task automatic clear_caps();
        txn = 0; rmn = 0; stn = 0; rdy_low = 0;
    endtask

    // Class tag is inverted after the start byte to exercise R11
    task automatic tx_send(input int n, input bit cls);
        int i;
        i = 0;
        while (i < n) begin
            @(negedge clk);
            if (tx_in_ready) begin
                tx_in_valid = 1'b1; tx_in_data = pay[i];
                tx_in_sof = (i == 0); tx_in_eof = (i == n - 1);
                tx_in_ctrl = (i == 0) ? cls : ~cls;
                i++;
            end else tx_in_valid = 1'b0;
        end
        @(negedge clk);
        tx_in_valid = 1'b0; tx_in_sof = 1'b0; tx_in_eof = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic rx_load(input int off, input int n, input bit corrupt);
        logic [31:0] f;
        f = ref_fcs(n);
        for (int i = 0; i < n + 4; i++) begin
            rxf[off+i] = (i < n) ? pay[i] : f[8*(i-n) +: 8];
            rs[off+i] = (i == 0); re[off+i] = (i == n + 3);
        end
        if (corrupt) rxf[off] = rxf[off] ^ 8'h10;
    endtask

    task automatic rx_send(input int n, input int flip_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == flip_at) rx_crc_keep = ~rx_crc_keep;
            rx_in_valid = 1'b1; rx_in_data = rxf[i];
            rx_in_sof = rs[i]; rx_in_eof = re[i];
            if (i == 0) sof_cyc = cyc;
            if (re[i]) eof_cyc = cyc;
        end
        @(negedge clk);
        rx_in_valid = 1'b0; rx_in_sof = 1'b0; rx_in_eof = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_in_ready == 1'b1, "R1", "tx_in_ready in reset", int'(tx_in_ready), 1);
        check(!tx_out_valid && !rx_mem_valid && !rx_stat_valid, "R1", "outputs idle in reset",
              int'({tx_out_valid, rx_mem_valid, rx_stat_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_in_ready && !tx_out_valid && !rx_mem_valid && !rx_stat_valid, "R1",
              "idle after reset release", int'({tx_in_ready, tx_out_valid, rx_mem_valid}), 4);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            logic [15:0] w;
            int n, exp_n, bad_i, exp_cnt;
            bit cls, off, keep, msk, cor, app;
            logic [31:0] f;
            logic [7:0] eb;
            string rq;
            w = VEC[v];
            cls = w[15]; off = w[14]; keep = w[13]; msk = w[12]; cor = w[11];
            n = int'(w[7:0]);
            for (int j = 0; j < n; j++) pay[j] = 8'(v * 37 + j * 11 + 3);
            f = ref_fcs(n);
            app = cls || !off;
            rq = cls ? "R4" : (off ? "R3" : "R2");
            tx_crc_off = off; rx_crc_keep = keep; rx_mask_crc_err = msk;
            clear_caps();
            tx_send(n, cls);
            exp_n = n + (app ? 4 : 0);
            check(txn == exp_n, rq, $sformatf("vec %0d tx length", v), txn, exp_n);
            bad_i = -1;
            for (int j = 0; j < exp_n && j < txn; j++) begin
                eb = (j < n) ? pay[j] : f[8*(j-n) +: 8];
                if (txcap[j] !== eb || txs[j] !== (j == 0) || txe[j] !== (j == exp_n - 1))
                    if (bad_i < 0) bad_i = j;
            end
            check(bad_i < 0, rq, $sformatf("vec %0d tx byte/marker at first bad index", v),
                  bad_i, -1);

            clear_caps();
            rx_load(0, n, cor);
            rx_send(n + 4, -1);
            exp_cnt = keep ? n + 4 : n;
            check(rmn == exp_cnt, keep ? "R7" : "R6", $sformatf("vec %0d delivered bytes", v),
                  rmn, exp_cnt);
            bad_i = -1;
            for (int j = 0; j < exp_cnt && j < rmn; j++)
                if (rmcap[j] !== rxf[j] || rml[j] !== (j == exp_cnt - 1))
                    if (bad_i < 0) bad_i = j;
            check(bad_i < 0, "R10", $sformatf("vec %0d delivered byte/last", v), bad_i, -1);
            check(stn == 1 && st_cnt[0] == exp_cnt, keep ? "R7" : "R6",
                  $sformatf("vec %0d status count", v), (stn == 1) ? st_cnt[0] : -stn, exp_cnt);
            check(stn == 1 && st_err[0] == cor, "R8", $sformatf("vec %0d crc error flag", v),
                  int'(st_err[0]), int'(cor));
            check(stn == 1 && st_acc[0] == (!cor || msk), "R9",
                  $sformatf("vec %0d accept flag", v), int'(st_acc[0]), int'(!cor || msk));
        end

        // R2 known value and R5 stall timing
        for (int j = 0; j < 9; j++) pay[j] = 8'h31 + 8'(j);
        tx_crc_off = 1'b0;
        clear_caps();
        tx_send(9, 1'b0);
        check(txn == 13 && {txcap[9], txcap[10], txcap[11], txcap[12]} == 32'h2639F4CB, "R2",
              "check value of 123456789", int'({txcap[9], txcap[10], txcap[11], txcap[12]}),
              32'h2639F4CB);
        check(rdy_low == 4, "R5", "cycles with ready low", rdy_low, 4);
        check(txn == 13 && (txcyc[12] - txcyc[0]) == 12, "R5", "output span in cycles",
              txcyc[12] - txcyc[0], 12);

        // R11: class tag changed to control after start of a data frame, CRC off
        for (int j = 0; j < 3; j++) pay[j] = 8'hA0 + 8'(j);
        tx_crc_off = 1'b1;
        clear_caps();
        tx_send(3, 1'b0);
        check(txn == 3 && txe[2], "R11", "tx class taken at start byte", txn, 3);

        // R10 latency, keep mode
        for (int j = 0; j < 2; j++) pay[j] = 8'h55 + 8'(j);
        rx_crc_keep = 1'b1; rx_mask_crc_err = 1'b0;
        clear_caps();
        rx_load(0, 2, 1'b0);
        rx_send(6, -1);
        check(rmn > 0 && rmcyc[0] == sof_cyc + 1, "R10", "first delivered byte cycle",
              rmcyc[0] - sof_cyc, 1);
        check(stn == 1 && st_cyc[0] == eof_cyc + 1, "R10", "status cycle after end byte",
              st_cyc[0] - eof_cyc, 1);

        // R6 strip-mode first delivery after the fifth byte
        rx_crc_keep = 1'b0;
        clear_caps();
        rx_send(6, -1);
        check(rmn == 2 && rmcyc[0] == sof_cyc + 5, "R6", "strip first delivery cycle",
              rmcyc[0] - sof_cyc, 5);

        // R11: keep mode flipped mid-frame has no effect
        rx_crc_keep = 1'b0;
        clear_caps();
        rx_send(6, 1);
        check(stn == 1 && st_cnt[0] == 2, "R11", "rx keep taken at start byte", st_cnt[0], 2);

        // Back-to-back: strip frame then keep frame starting next cycle
        rx_crc_keep = 1'b0;
        for (int j = 0; j < 2; j++) pay[j] = 8'h11 * 8'(j + 1);
        rx_load(0, 2, 1'b0);
        for (int j = 0; j < 3; j++) pay[j] = 8'hC3 ^ 8'(j);
        rx_load(6, 3, 1'b0);
        clear_caps();
        rx_send(13, 6);
        check(stn == 2 && st_cnt[0] == 2 && st_cnt[1] == 7, "R6",
              "back-to-back counts", st_cnt[0] * 100 + st_cnt[1], 207);
        check(stn == 2 && (st_cyc[1] - st_cyc[0]) == 7 && !st_err[0] && !st_err[1], "R8",
              "back-to-back status spacing", st_cyc[1] - st_cyc[0], 7);

        done = 1'b1;
        report();
        $finish;
    end

endmodule